// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block derives the clock that drives a memory card interface from the system clock. A host writes a 10-bit divisor N; the card clock then runs with a full period of 2×(N+1) system clock cycles, high and low for N+1 cycles each. A divisor of zero stops the card clock and holds it low. That is also the state after reset.

A divisor change never shortens or stretches a half-period that is already running. The new value is taken up only when the current half-period ends. A write that arrives in the very cycle a half-period ends is used for the half-period that starts there. From the stopped state, a nonzero write restarts the clock at once, and the clock starts with a low phase.

Next to the clock itself, the block gives the shift logic two single-cycle strobes in the system clock domain. One marks each rising edge of the card clock and the other marks each falling edge. Each strobe is high in the same cycle as the new clock level.

Top module: `card_clk_divider`

## Requirements
- R1: After reset the divisor reads 0, the card clock is low and neither strobe is asserted.
- R2: A divisor written with `div_wr_en` high is returned on `div_rd_data` from the next cycle on, all 10 bits.
- R3: With a steady nonzero divisor N, the card clock is high for N+1 cycles and low for N+1 cycles, a period of 2×(N+1) system cycles.
- R4: While the divisor is 0, the card clock stays low and no strobe is produced.
- R5: Writing nonzero N while the clock is stopped starts a low phase at the write edge. The first rising edge comes N+1 cycles after the edge that captured the write.
- R6: A divisor written during a half-period does not change that half-period's length. The next half-period uses the new value.
- R7: A divisor written in the same cycle a half-period ends sets the length of the half-period that starts at that boundary.
- R8: Writing 0 while the card clock is high lets the high phase finish. The clock then falls, with a falling strobe, and stays low.
- R9: `rise_stb` is high for exactly the cycle in which the card clock first reads 1, and `fall_stb` for exactly the cycle in which it first reads 0. The two are never high together.
- R10: The largest divisor, 1023, gives a period of 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr_en | input | 1 | Host write enable for the divisor |
| div_wr_data | input | 10 | Divisor value to write |
| div_rd_data | output | 10 | Current host-visible divisor |
| card_clk | output | 1 | Divided card clock |
| rise_stb | output | 1 | One-cycle strobe on a card clock rising edge |
| fall_stb | output | 1 | One-cycle strobe on a card clock falling edge |

## Verification
A host write and the end of a half-period can land in the same cycle. The design must then start the new half-period with the value being written, not with the value it held before. The bench provokes this by timing a write so that it is captured on the exact edge where the card clock falls. It then checks that the next rising edge follows after the new, shorter half-length; the old divisor would give a later edge. A second case places a write in the middle of a high phase and checks that the fall keeps its old timing.

// File: rtl/ccd_pkg.sv
// Shared definitions for the card clock divider.
// Assumes nothing beyond a single system clock domain.
package ccd_pkg;

    // Default divisor width used by the top module.
    localparam int unsigned CCD_DIV_W = 10;

    // Kind of card clock transition decided for the next cycle.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;

endpackage

// File: rtl/cdiv_host_reg.sv
// Host-visible divisor register.
// Holds the last written divisor and offers the value that a reload in the
// current cycle must use: the write data when a write is present, otherwise
// the stored value. Assumes writes are single-cycle qualified by wr_en.
module cdiv_host_reg #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] rd_data,
    output logic [DIV_W-1:0] next_div
);

    logic [DIV_W-1:0] div_q;

    // Store the divisor on a host write; reset to the stopped value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

    // Bypass so that a write coinciding with a reload is used at once.
    always_comb begin
        next_div = wr_en ? wr_data : div_q;
    end

    assign rd_data = div_q;

endmodule

// File: rtl/cdiv_half_counter.sv
// Half-period counter with a shadow divisor.
// The shadow copy is reloaded only when a half-period ends or while stopped,
// which keeps a divisor change from cutting a half-period short. The counter
// runs 0..shadow and flags the last cycle of each half-period as `boundary`.
// Assumes next_div already reflects any write in the current cycle.
module cdiv_half_counter #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] next_div,
    output logic             boundary
);

    logic [DIV_W-1:0] shadow_q;
    logic [DIV_W-1:0] count_q;
    logic             halted;

    // A zero shadow divisor means the card clock is stopped.
    always_comb begin
        halted   = (shadow_q == '0);
        boundary = !halted && (count_q == shadow_q);
    end

    // Advance the count, or reload the shadow at a boundary / while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            count_q  <= '0;
        end else if (halted || boundary) begin
            shadow_q <= next_div;
            count_q  <= '0;
        end else begin
            count_q  <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdiv_edge_gen.sv
// Card clock output stage.
// Toggles the card clock at each half-period boundary, forces it low when the
// reloaded divisor is zero, and registers one-cycle edge strobes aligned with
// the new clock level. Assumes boundary is a single-cycle pulse.
module cdiv_edge_gen
    import ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic reload_zero,
    output logic card_clk,
    output logic rise_stb,
    output logic fall_stb
);

    logic       clk_q;
    logic       rise_q;
    logic       fall_q;
    edge_kind_e edge_kind;

    // Decide which transition, if any, the next edge performs.
    always_comb begin
        edge_kind = EDGE_NONE;
        if (boundary) begin
            if (clk_q) begin
                edge_kind = EDGE_FALL;
            end else if (!reload_zero) begin
                edge_kind = EDGE_RISE;
            end
        end
    end

    // Register the card clock level and the matching strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= (edge_kind == EDGE_RISE);
            fall_q <= (edge_kind == EDGE_FALL);
            case (edge_kind)
                EDGE_RISE: clk_q <= 1'b1;
                EDGE_FALL: clk_q <= 1'b0;
                default:   clk_q <= clk_q;
            endcase
        end
    end

    assign card_clk = clk_q;
    assign rise_stb = rise_q;
    assign fall_stb = fall_q;

endmodule

// File: rtl/card_clk_divider.sv
// Programmable card clock divider, top level.
// Divides the system clock by 2*(N+1) for a host divisor N; N = 0 stops the
// card clock low. Divisor changes take effect at half-period boundaries.
// Assumes one clock domain and a synchronous active-low reset.
module card_clk_divider
    import ccd_pkg::*;
#(
    parameter int unsigned DIV_W = CCD_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr_en,
    input  logic [DIV_W-1:0] div_wr_data,
    output logic [DIV_W-1:0] div_rd_data,
    output logic             card_clk,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] next_div;
    logic             boundary;
    logic             reload_zero;

    // A zero reload value stops the card clock.
    always_comb begin
        reload_zero = (next_div == '0);
    end

    cdiv_host_reg #(.DIV_W(DIV_W)) host_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (div_wr_en),
        .wr_data  (div_wr_data),
        .rd_data  (div_rd_data),
        .next_div (next_div)
    );

    cdiv_half_counter #(.DIV_W(DIV_W)) half_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_div (next_div),
        .boundary (boundary)
    );

    cdiv_edge_gen edge_gen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .reload_zero (reload_zero),
        .card_clk    (card_clk),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb)
    );

endmodule

// File: rtl/card_clk_divider_chk.sv
// Property checker for the card clock divider, attached by bind.
// Observes only the top-level ports.
module card_clk_divider_chk #(
    parameter int unsigned DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_wr_en,
    input logic [DIV_W-1:0] div_wr_data,
    input logic [DIV_W-1:0] div_rd_data,
    input logic             card_clk,
    input logic             rise_stb,
    input logic             fall_stb
);

    // R9: strobes are mutually exclusive.
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R9: a rise strobe marks the first high cycle.
    assert_rise_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rise_stb) |-> (card_clk && !$past(card_clk)));

    // R9: a fall strobe marks the first low cycle.
    assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fall_stb) |-> (!card_clk && $past(card_clk)));

    // R9: every change of the card clock carries a strobe.
    assert_change_has_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (card_clk != $past(card_clk))) |-> (rise_stb || fall_stb));

    // R2: a written divisor reads back on the next cycle.
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(div_wr_en)) |-> (div_rd_data == $past(div_wr_data)));

    // R4: a zero divisor with the clock low keeps it low.
    assert_zero_holds_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rd_data == '0 && !div_wr_en && !card_clk) |=> !card_clk);

endmodule

bind card_clk_divider card_clk_divider_chk #(.DIV_W(DIV_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_wr_en   (div_wr_en),
    .div_wr_data (div_wr_data),
    .div_rd_data (div_rd_data),
    .card_clk    (card_clk),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb)
);

// File: tb/card_clk_divider_tb_top.sv
// Scoreboard bench: scenario tasks push expected edges (kind, cycle) into a
// queue; a monitor pops and compares each strobe the design produces.
module card_clk_divider_tb_top;

    localparam int DIV_W    = 10;
    localparam time CLK_PER = 10ns;
    localparam int WDOG_CYC = 150000;

    typedef struct {
        bit rise;
        int cyc;
        string req;
    } exp_edge_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_wr_en = 1'b0;
    logic [DIV_W-1:0] div_wr_data = '0;
    logic [DIV_W-1:0] div_rd_data;
    logic             card_clk;
    logic             rise_stb;
    logic             fall_stb;

    int        cyc = 0;
    int        n_checks = 0;
    int        n_fail = 0;
    bit        done = 1'b0;
    exp_edge_t exp_q[$];

    card_clk_divider #(.DIV_W(DIV_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_wr_en   (div_wr_en),
        .div_wr_data (div_wr_data),
        .div_rd_data (div_rd_data),
        .card_clk    (card_clk),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb)
    );

    always #(CLK_PER / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare every strobe with the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rise_stb && fall_stb) begin
                check(1'b0, "R9", "both strobes high", 1, 0);
            end else if (rise_stb || fall_stb) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected edge at cycle", cyc, -1);
                end else begin
                    exp_edge_t e;
                    e = exp_q.pop_front();
                    check(e.rise == rise_stb, e.req, "edge kind (1=rise)",
                          int'(rise_stb), int'(e.rise));
                    check(e.cyc == cyc, e.req, "edge cycle", cyc, e.cyc);
                    check(card_clk == rise_stb, "R9", "clock level at strobe",
                          int'(card_clk), int'(rise_stb));
                end
            end
        end
    end

    task automatic push(input bit rise, input int c, input string req);
        exp_edge_t e;
        e.rise = rise;
        e.cyc  = c;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // Called at a negedge; the write is captured at the next posedge.
    task automatic write_div(input int v, output int w);
        div_wr_en   = 1'b1;
        div_wr_data = DIV_W'(v);
        @(posedge clk);
        @(negedge clk);
        div_wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_drained(input string req);
        check(exp_q.size() == 0, req, "expected edges left pending",
              exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= WDOG_CYC);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "WDOG", "watchdog expired at cycle", cyc, WDOG_CYC);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int w;

        // R1: reset state.
        do_reset();
        check(div_rd_data == '0, "R1", "divisor after reset", int'(div_rd_data), 0);
        check(card_clk == 1'b0, "R1", "card clock after reset", int'(card_clk), 0);
        check(!rise_stb && !fall_stb, "R1", "strobes after reset",
              int'(rise_stb) + int'(fall_stb), 0);
        wait_to(cyc + 20);
        check(card_clk == 1'b0, "R4", "stopped clock after reset", int'(card_clk), 0);

        // R2, R3, R5: start N=3 from stop.
        write_div(3, w);
        check(div_rd_data == 10'd3, "R2", "readback of 3", int'(div_rd_data), 3);
        push(1'b1, w + 4,  "R5");
        push(1'b0, w + 8,  "R3");
        push(1'b1, w + 12, "R3");
        push(1'b0, w + 16, "R3");
        wait_to(w + 17);
        check_drained("R3");
        do_reset();

        // R4: explicit zero keeps clock stopped.
        write_div(0, w);
        check(div_rd_data == '0, "R2", "readback of 0", int'(div_rd_data), 0);
        wait_to(w + 30);
        check(card_clk == 1'b0, "R4", "clock with zero divisor", int'(card_clk), 0);
        check_drained("R4");

        // R3: minimum nonzero divisor.
        write_div(1, w);
        push(1'b1, w + 2, "R5");
        push(1'b0, w + 4, "R3");
        push(1'b1, w + 6, "R3");
        push(1'b0, w + 8, "R3");
        wait_to(w + 9);
        check_drained("R3");
        do_reset();

        // R6: change in the middle of a high phase.
        write_div(5, w);
        push(1'b1, w + 6,  "R5");
        push(1'b0, w + 12, "R6");
        push(1'b1, w + 15, "R6");
        push(1'b0, w + 18, "R6");
        begin
            int w2;
            wait_to(w + 7);
            write_div(2, w2);
        end
        wait_to(w + 19);
        check_drained("R6");
        do_reset();

        // R7: write captured on the same edge a half-period ends.
        write_div(4, w);
        push(1'b1, w + 5,  "R5");
        push(1'b0, w + 10, "R7");
        push(1'b1, w + 12, "R7");
        push(1'b0, w + 14, "R7");
        begin
            int w2;
            wait_to(w + 9);
            write_div(1, w2);
        end
        wait_to(w + 15);
        check_drained("R7");
        do_reset();

        // R8: zero written while high.
        write_div(2, w);
        push(1'b1, w + 3, "R5");
        push(1'b0, w + 6, "R8");
        begin
            int w2;
            wait_to(w + 3);
            write_div(0, w2);
        end
        wait_to(w + 40);
        check(card_clk == 1'b0, "R8", "clock after zero write", int'(card_clk), 0);
        check_drained("R8");
        do_reset();

        // R10: largest divisor.
        write_div(1023, w);
        check(div_rd_data == 10'd1023, "R2", "readback of 1023", int'(div_rd_data), 1023);
        push(1'b1, w + 1024, "R10");
        push(1'b0, w + 2048, "R10");
        push(1'b1, w + 3072, "R10");
        wait_to(w + 3073);
        check_drained("R10");
        do_reset();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule